// File: doc/BRIEF.md
# Warm Reset Quiesce Sequencer

This block runs a hardware-sequenced warm reset. When a warm reset is requested, it does not assert reset at once. It first asks four neighbouring agents to reach a safe state, one at a time, and waits for each agent's acknowledge before it moves on. Each wait is bounded by a cycle-count timeout, so an agent that never answers cannot hang the sequence.

The four steps run in a fixed order: the memory controller enters self-refresh, the configuration clock stops, the fabric handshake completes, and the trace master port stalls. A step that times out still lets the sequence go on. It also sets a sticky flag in a 32-bit status word. Software reads that word and clears flags by writing ones to them.

Once all four steps are resolved, the warm reset output is held high for a fixed number of cycles. All requests are then released together and the sequencer goes back to idle. Only the cold reset input clears the flags and the sequencer state.

Top module: `warm_rst_seq`

## Requirements
- R1: Requests are issued in the order bit 0 (self-refresh), bit 1 (clock stop), bit 2 (fabric handshake), bit 3 (trace stall). A request stays high once issued, so `qreq` only ever holds 0000, 0001, 0011, 0111 or 1111. The next request is raised on the clock edge at which the current step resolves.
- R2: A step resolves on the first clock edge at which its own acknowledge `qack[k]` is sampled high. An acknowledge sampled on the last cycle of the timeout window also counts as success and sets no flag.
- R3: A step whose acknowledge stays low for `TIMEOUT_CYCLES` sampled edges times out. The sequence goes on to the next step, and status bit k is set, where k is the step's request index from R1.
- R4: After the fourth step resolves, `warm_rst` is high for exactly `HOLD_CYCLES` cycles while `qreq` is 1111. After that, `qreq` returns to 0000 and `warm_rst` returns to 0.
- R5: A warm reset sequence never clears a status flag. Flags logged earlier survive later sequences.
- R6: A register write with `reg_wen` high clears each flag whose bit in `reg_wdata[3:0]` is 1. Bits written as 0 leave their flags unchanged.
- R7: If a timeout sets a flag on the same edge as a write of 1 to that flag, the flag ends up set.
- R8: While `cold_rst_n` is low, `qreq`, `warm_rst` and all flags are 0. The sequencer is idle when reset is released.
- R9: `reg_rdata[3:0]` returns the four flags, and `reg_rdata[31:4]` always reads as 0.
- R10: A `warm_req` that is high while a sequence is running is ignored. It starts no second sequence after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_req | input | 1 | Request to start a warm reset sequence; sampled only when idle |
| qack | input | 4 | Quiesce acknowledges, one per step |
| qreq | output | 4 | Quiesce requests, one per step |
| warm_rst | output | 1 | Warm reset output |
| reg_wen | input | 1 | Status write strobe |
| reg_wdata | input | 32 | Write data; ones clear the matching flags |
| reg_rdata | output | 32 | Status read data |

## Verification
The hardest case to reach is a timeout setting a flag on the exact edge where software writes a one to clear that same flag. The two events come from unrelated sources and have to land in the same cycle. The bench gets there by never acknowledging the first step. It then counts `TIMEOUT_CYCLES` falling edges from the request and drives the clearing write in that cycle. It also checks that the flag is still clear one cycle earlier, so a misaligned write would be seen.

The boundary of the acknowledge window is covered by vectors that acknowledge exactly on the last cycle of the window and exactly one cycle later. For each vector, the bench compares the measured time until `warm_rst` rises with a time it computes from the per-step delays.

// File: rtl/warm_rst_seq.sv
module warm_rst_seq #(
  parameter int unsigned TIMEOUT_CYCLES = 64,
  parameter int unsigned HOLD_CYCLES    = 8,
  parameter int unsigned DATA_W         = 32
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_req,
  input  logic [3:0]        qack,
  output logic [3:0]        qreq,
  output logic              warm_rst,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_HS, S_HOLD} st_t;

  st_t         st;
  logic [1:0]  idx;
  logic [TW-1:0] tmr;
  logic [HW-1:0] hcnt;
  logic [3:0]  issued;
  logic [3:0]  stat;

  logic ack_now, to_now, step_done;
  logic [3:0] set_vec, clr_vec;

  assign ack_now   = qack[idx];
  assign to_now    = (tmr == TMR_LAST);
  assign step_done = (st == S_HS) && (ack_now || to_now);
  assign set_vec   = (st == S_HS && !ack_now && to_now) ? (4'b0001 << idx) : 4'b0000;
  assign clr_vec   = reg_wen ? reg_wdata[3:0] : 4'b0000;

  assign qreq      = issued;
  assign warm_rst  = (st == S_HOLD);
  assign reg_rdata = {{(DATA_W-4){1'b0}}, stat};

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      tmr    <= '0;
      hcnt   <= '0;
      issued <= '0;
    end else begin
      case (st)
        S_IDLE: if (warm_req) begin
          st     <= S_HS;
          idx    <= '0;
          tmr    <= '0;
          issued <= 4'b0001;
        end
        S_HS: begin
          if (step_done) begin
            tmr <= '0;
            if (idx == 2'd3) begin
              st   <= S_HOLD;
              hcnt <= '0;
            end else begin
              idx    <= idx + 2'd1;
              issued <= issued | (4'b0010 << idx);
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_HOLD: begin
          if (hcnt == HOLD_LAST) begin
            st     <= S_IDLE;
            issued <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) stat <= '0;
    else             stat <= (stat & ~clr_vec) | set_vec;
  end

  assert_req_thermo_R1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((qreq & (qreq + 4'd1)) == 4'd0));

  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (st == S_HS) |-> (tmr < TW'(TIMEOUT_CYCLES)));

  assert_rst_after_all_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst |-> (qreq == 4'hF));

  assert_flag_set_in_seq_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((stat & ~$past(stat)) != 4'd0) |-> ($past(st) == S_HS));

  assert_flag_clear_by_sw_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (($past(stat) & ~stat) != 4'd0) |-> $past(reg_wen));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (($past(set_vec) & ~stat) == 4'd0));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ($past(st) == S_HS) |-> (st != S_IDLE));

endmodule

// File: tb/sim_warm_rst_seq.sv
`timescale 1ns/1ps
module sim_warm_rst_seq;
  localparam int T = 8;
  localparam int H = 3;
  localparam logic [3:0] NEVER = 4'hF;

  logic clk = 0, cold_rst_n = 0, warm_req = 0, reg_wen = 0, warm_rst;
  logic [3:0] qack = '0, qreq;
  logic [31:0] reg_wdata = '0, reg_rdata;

  warm_rst_seq #(.TIMEOUT_CYCLES(T), .HOLD_CYCLES(H)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_req(warm_req), .qack(qack),
    .qreq(qreq), .warm_rst(warm_rst), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [3:0] dly [4];
  int cnt [4];
  logic order_bad = 0;

  // {d0,d1,d2,d3,expected flags}
  localparam logic [19:0] VEC [7] = '{
    {4'h0, 4'h0, 4'h0, 4'h0, 4'b0000},
    {4'hF, 4'hF, 4'hF, 4'hF, 4'b1111},
    {4'h7, 4'h8, 4'h0, 4'h3, 4'b0010},
    {4'h8, 4'h2, 4'hF, 4'h7, 4'b0101},
    {4'h1, 4'hF, 4'h5, 4'hC, 4'b1010},
    {4'h3, 4'h3, 4'h3, 4'h3, 4'b0000},
    {4'h6, 4'h7, 4'h8, 4'h9, 4'b1100}
  };

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (!qreq[k]) begin
        cnt[k]  <= 0;
        qack[k] <= 1'b0;
      end else begin
        if (dly[k] != NEVER && cnt[k] >= int'(dly[k])) qack[k] <= 1'b1;
        cnt[k] <= cnt[k] + 1;
      end
    end
    if ((qreq & (qreq + 4'd1)) != 4'd0) order_bad <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [15:0] d);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int v = (d[15-4*k -: 4] == NEVER) ? T : int'(d[15-4*k -: 4]) + 1;
      s += (v > T) ? T : v;
    end
    return s + 1;
  endfunction

  task automatic set_dly(input logic [15:0] d);
    for (int k = 0; k < 4; k++) dly[k] = d[15-4*k -: 4];
  endtask

  task automatic run_seq(input bit poke, output int lat, output int width);
    lat = 0; width = 0;
    @(negedge clk) warm_req = 1;
    while (!warm_rst && lat < 500) begin
      @(negedge clk); lat++;
      warm_req = (poke && lat == 3);
    end
    warm_req = 0;
    check("R4 reqs all high in reset", {28'd0, qreq}, 32'hF);
    while (warm_rst && width < 100) begin
      @(negedge clk); width++;
    end
    check("R4 reqs released", {28'd0, qreq}, 32'h0);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk) begin reg_wen = 1; reg_wdata = d; end
    @(negedge clk) begin reg_wen = 0; reg_wdata = '0; end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat, width;
    for (int k = 0; k < 4; k++) dly[k] = 4'h0;
    repeat (3) @(negedge clk);
    check("R8 reset rdata", reg_rdata, 32'h0);
    check("R8 reset outputs", {27'd0, warm_rst, qreq}, 32'h0);
    cold_rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      order_bad = 0;
      set_dly(VEC[v][19:4]);
      run_seq(1'b0, lat, width);
      check("R2 R3 latency to warm reset", lat, exp_lat(VEC[v][19:4]));
      check("R4 warm reset width", width, H);
      check("R1 request order", {31'd0, order_bad}, 32'd0);
      check("R3 R9 flags", reg_rdata, {28'd0, VEC[v][3:0]});
      wr(32'hF);
      check("R6 clear all", reg_rdata, 32'h0);
    end

    // R6 partial clear, write of zeros, reserved bits
    set_dly({NEVER, NEVER, NEVER, NEVER});
    run_seq(1'b0, lat, width);
    wr(32'hFFFF_FFF0);
    check("R6 R9 zeros in flag bits", reg_rdata, 32'hF);
    wr(32'h5);
    check("R6 partial clear", reg_rdata, 32'hA);

    // R5 sticky across a clean warm reset
    set_dly(16'h0000);
    run_seq(1'b0, lat, width);
    check("R5 flags survive warm reset", reg_rdata, 32'hA);
    wr(32'hF);

    // R10 request during sequence ignored
    set_dly(16'h2222);
    run_seq(1'b1, lat, width);
    check("R10 latency unchanged", lat, exp_lat(16'h2222));
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (warm_rst || qreq != 0) begin
        check("R10 no second sequence", {27'd0, warm_rst, qreq}, 32'h0);
        break;
      end
    end
    check("R10 idle after", {27'd0, warm_rst, qreq}, 32'h0);

    // R7 set beats same-cycle clear
    set_dly({NEVER, 12'h000});
    @(negedge clk) warm_req = 1;
    @(negedge clk) warm_req = 0;
    repeat (T - 2) @(negedge clk);
    @(negedge clk) begin
      check("R7 flag clear before timeout", reg_rdata, 32'h0);
      reg_wen = 1; reg_wdata = 32'h1;
    end
    @(negedge clk) begin reg_wen = 0; reg_wdata = 0; end
    check("R7 set wins", reg_rdata, 32'h1);
    while (!warm_rst) @(negedge clk);
    while (warm_rst) @(negedge clk);

    // R8 cold reset mid-sequence
    set_dly({NEVER, NEVER, NEVER, NEVER});
    @(negedge clk) warm_req = 1;
    @(negedge clk) warm_req = 0;
    repeat (T + 3) @(negedge clk);
    check("R8 sequence running", {28'd0, qreq}, 32'h3);
    cold_rst_n = 0;
    @(negedge clk);
    check("R8 cold reset clears flags", reg_rdata, 32'h0);
    check("R8 cold reset outputs", {27'd0, warm_rst, qreq}, 32'h0);
    cold_rst_n = 1;
    repeat (3) @(negedge clk);
    check("R8 idle after release", {27'd0, warm_rst, qreq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule